// File: doc/BRIEF.md
# Ratio-Preserving Vector Type Modifier

This block carries out one configuration-modify operation on a vector type word. A decoder hands it the three 5-bit register-specifier fields of the instruction, and the block reads them as immediate modification bits. It also receives the current type word. The block can scale the element width and the register-group multiplier by the same power of two, which leaves their quotient unchanged. The number of elements per vector therefore does not move. It can also set the tail-agnostic and mask-agnostic flags.

The result is registered. One cycle after the operation strobe, the block presents the next type word with a write enable. If the request cannot be honoured, it raises an illegal-instruction flag for one cycle instead, leaves the write enable low, and passes the current type word through unchanged. The block never produces a vector length. Any request that would change the vector length is refused.

Type word layout:

| Bits | Field | Encoding |
|------|-------|----------|
| [2:0] | multiplier | signed exponent: 0..3 give 1, 2, 4, 8; 5..7 give 1/8, 1/4, 1/2; 4 is reserved |
| [5:3] | width | 0..3 give 8, 16, 32, 64; 4..7 are reserved |
| [6] | tail-agnostic flag | |
| [7] | mask-agnostic flag | |
| [XLEN-1] | configuration-invalid bit | |

Top module: `vtype_ratio_mod`

## Requirements
- R1: While reset is held and in the cycle after it is released, `vtype_we` and `illegal_op` are 0 and `vtype_nxt` is all zeros.
- R2: Results appear on the outputs exactly one clock after `op_valid` is sampled high. In a cycle that follows no strobe, `vtype_we` and `illegal_op` are both 0.
- R3: The scale exponent k is `rs2_fld[2:0]` read as a signed number, so 0..3 give +0..+3 and 5..7 give -3..-1. On success the width code becomes the old code plus k, and the multiplier exponent becomes the old exponent plus k, written back as a 3-bit two's-complement value in bits [2:0].
- R4: If the scaled multiplier exponent exceeds 3 (a multiplier above 8), the operation fails.
- R5: If the scaled width code leaves 0..3 (a width above 64 or below 8), the operation fails. If the scaled multiplier exponent falls below -3 (a multiplier below 1/8), the operation fails.
- R6: A non-zero `rd_fld` or a non-zero `rs1_fld` is reserved, and either one makes the operation fail.
- R7: The operation fails if any of these holds: the configuration-invalid bit (bit XLEN-1) of `vtype_cur` is set, the current width code is 4..7, the current multiplier code is 4, or the scale code `rs2_fld[2:0]` is 4.
- R8: On success, `rs2_fld[3]`=1 sets bit 6 and `rs2_fld[4]`=1 sets bit 7. A 0 in either select bit leaves the matching flag as it was. Every bit outside [7:0] is copied unchanged.
- R9: On failure, `illegal_op` is 1 and `vtype_we` is 0 for exactly that one result cycle, and `vtype_nxt` equals the `vtype_cur` that was sampled.
- R10: Whenever `vtype_we` is 1, the written word's width code minus its signed multiplier exponent equals the same difference taken on the sampled input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per request |
| rd_fld | input | 5 | Destination specifier field (reserved, must be 0) |
| rs1_fld | input | 5 | First source specifier field (reserved, must be 0) |
| rs2_fld | input | 5 | Modification bits: [2:0] scale exponent, [3] tail flag set, [4] mask flag set |
| vtype_cur | input | XLEN | Current vector type word |
| vtype_nxt | output | XLEN | Next vector type word, or the unchanged input on failure |
| vtype_we | output | 1 | Write enable for `vtype_nxt` |
| illegal_op | output | 1 | One-cycle illegal-instruction flag |

## Verification
A fault in the scaler shows on the outputs in the cycle after the strobe. It appears either as a written word whose width-to-multiplier difference has drifted, or as a write where a fault was due, or as a fault where a write was due. Because every result is registered only once and nothing accumulates, a bad legality decision or a bad field merge can never hide behind later operations. The scoreboard therefore compares each result against an independently computed word in the cycle after its strobe. A stuck pipeline register shows up as a missing or lingering enable in the cycle after an idle input.

// File: rtl/vmod_pkg.sv
package vmod_pkg;
  localparam int LMUL_LSB  = 0;
  localparam int SEW_LSB   = 3;
  localparam int FLAG_LSB  = 6;
  localparam int NUM_FLAGS = 2;
  localparam int CODE_W    = 3;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] sew;
    logic [CODE_W-1:0] lmul;
  } scale_res_t;

  // signed 3-bit code to int
  function automatic int sext3(input logic [CODE_W-1:0] c);
    return c[CODE_W-1] ? int'(c) - 8 : int'(c);
  endfunction

  // width exponent minus multiplier exponent: invariant under legal scaling
  function automatic int ratio_key(input logic [CODE_W-1:0] sew,
                                   input logic [CODE_W-1:0] lmul);
    return int'(sew) - sext3(lmul);
  endfunction

  function automatic scale_res_t rescale(input logic [CODE_W-1:0] sew,
                                         input logic [CODE_W-1:0] lmul,
                                         input logic [CODE_W-1:0] k);
    scale_res_t r;
    int ns;
    int nl;
    ns = int'(sew) + sext3(k);
    nl = sext3(lmul) + sext3(k);
    r.ok   = (sew <= 3'd3) && (lmul != 3'd4) && (k != 3'd4) &&
             (ns >= 0) && (ns <= 3) && (nl >= -3) && (nl <= 3);
    r.sew  = 3'(ns);
    r.lmul = 3'(nl);
    return r;
  endfunction
endpackage

// File: rtl/vmod_field_chk.sv
module vmod_field_chk #(
  parameter int XLEN  = 32,
  parameter int SPEC_W = 5
) (
  input  logic [SPEC_W-1:0] rd_fld,
  input  logic [SPEC_W-1:0] rs1_fld,
  input  logic [XLEN-1:0]   vtype_cur,
  output logic              reserved_hit,
  output logic              vill_hit
);
  assign reserved_hit = (rd_fld != '0) || (rs1_fld != '0);
  assign vill_hit     = vtype_cur[XLEN-1];
endmodule

// File: rtl/vmod_scaler.sv
module vmod_scaler (
  input  logic [2:0] sew_in,
  input  logic [2:0] lmul_in,
  input  logic [2:0] k_in,
  output logic       scale_ok,
  output logic [2:0] sew_out,
  output logic [2:0] lmul_out
);
  import vmod_pkg::*;
  scale_res_t res;
  always_comb begin
    res      = rescale(sew_in, lmul_in, k_in);
    scale_ok = res.ok;
    sew_out  = res.sew;
    lmul_out = res.lmul;
  end
endmodule

// File: rtl/vtype_ratio_mod.sv
module vtype_ratio_mod #(
  parameter int XLEN   = 32,
  parameter int SPEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [SPEC_W-1:0] rd_fld,
  input  logic [SPEC_W-1:0] rs1_fld,
  input  logic [SPEC_W-1:0] rs2_fld,
  input  logic [XLEN-1:0]   vtype_cur,
  output logic [XLEN-1:0]   vtype_nxt,
  output logic              vtype_we,
  output logic              illegal_op
);
  import vmod_pkg::*;
  localparam int K_LSB   = 0;
  localparam int SEL_LSB = K_LSB + CODE_W;

  logic              reserved_hit;
  logic              vill_hit;
  logic              scale_ok;
  logic [CODE_W-1:0] sew_new;
  logic [CODE_W-1:0] lmul_new;
  logic              op_ok;
  logic [XLEN-1:0]   merged;
  logic [NUM_FLAGS-1:0] flag_new;

  vmod_field_chk #(.XLEN(XLEN), .SPEC_W(SPEC_W)) u_chk (
    .rd_fld(rd_fld), .rs1_fld(rs1_fld), .vtype_cur(vtype_cur),
    .reserved_hit(reserved_hit), .vill_hit(vill_hit)
  );

  vmod_scaler u_scale (
    .sew_in  (vtype_cur[SEW_LSB +: CODE_W]),
    .lmul_in (vtype_cur[LMUL_LSB +: CODE_W]),
    .k_in    (rs2_fld[K_LSB +: CODE_W]),
    .scale_ok(scale_ok),
    .sew_out (sew_new),
    .lmul_out(lmul_new)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_new[i] = vtype_cur[FLAG_LSB+i] | rs2_fld[SEL_LSB+i];
  end

  assign op_ok = scale_ok && !reserved_hit && !vill_hit;

  always_comb begin
    merged = vtype_cur;
    merged[SEW_LSB +: CODE_W]     = sew_new;
    merged[LMUL_LSB +: CODE_W]    = lmul_new;
    merged[FLAG_LSB +: NUM_FLAGS] = flag_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtype_nxt  <= '0;
      vtype_we   <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      vtype_we   <= op_valid && op_ok;
      illegal_op <= op_valid && !op_ok;
      if (op_valid) vtype_nxt <= op_ok ? merged : vtype_cur;
    end
  end

  // R9: write and fault never together
  p_we_ill_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vtype_we && illegal_op));

  // R2: idle input gives quiet outputs
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!vtype_we && !illegal_op));

  // R6: reserved specifiers fault
  p_reserved_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (rd_fld != '0 || rs1_fld != '0)) |=> illegal_op);

  // R7: invalid configuration faults
  p_vill_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && vtype_cur[XLEN-1]) |=> illegal_op);

  // R10: ratio preserved on every write
  p_ratio_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (!vtype_we ||
      ratio_key(vtype_nxt[SEW_LSB +: CODE_W], vtype_nxt[LMUL_LSB +: CODE_W]) ==
      ratio_key($past(vtype_cur[SEW_LSB +: CODE_W]),
                $past(vtype_cur[LMUL_LSB +: CODE_W]))));

  // R4 / R5: written codes stay inside legal ranges
  p_codes_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_we |-> (vtype_nxt[LMUL_LSB +: CODE_W] != 3'd4 &&
                  vtype_nxt[SEW_LSB +: CODE_W] <= 3'd3));

  // R9: a failed request passes the input word through
  p_fail_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (!illegal_op || vtype_nxt == $past(vtype_cur)));
endmodule

// File: tb/tb_vtype_ratio_mod.sv
module tb_vtype_ratio_mod;
  localparam int XLEN = 32;

  typedef struct {
    logic            we;
    logic            ill;
    logic [XLEN-1:0] vt;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic [4:0]      rd_fld = '0, rs1_fld = '0, rs2_fld = '0;
  logic [XLEN-1:0] vtype_cur = '0;
  logic [XLEN-1:0] vtype_nxt;
  logic            vtype_we, illegal_op;

  int n_checks = 0;
  int n_fail = 0;
  bit monitor_on = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  vtype_ratio_mod #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .rd_fld(rd_fld), .rs1_fld(rs1_fld), .rs2_fld(rs2_fld),
    .vtype_cur(vtype_cur), .vtype_nxt(vtype_nxt),
    .vtype_we(vtype_we), .illegal_op(illegal_op)
  );

  // Independent model: works in element widths and multiplier exponents
  function automatic exp_t model(input logic [4:0] rd, input logic [4:0] rs1,
                                 input logic [4:0] rs2, input logic [XLEN-1:0] vt,
                                 input string tag);
    exp_t e;
    int k, width, nwidth, lexp, nlexp, code;
    bit good;
    k     = rs2[2] ? int'(rs2[2:0]) - 8 : int'(rs2[2:0]);
    lexp  = vt[2] ? int'(vt[2:0]) - 8 : int'(vt[2:0]);
    good  = (rd == 0) && (rs1 == 0) && !vt[XLEN-1] && (vt[5:3] < 4) &&
            (vt[2:0] != 3'd4) && (rs2[2:0] != 3'd4);
    width = 8 << vt[5:3];
    nwidth = (k >= 0) ? (width << k) : (width >> (-k));
    nlexp = lexp + k;
    good  = good && nwidth >= 8 && nwidth <= 64 && nlexp >= -3 && nlexp <= 3;
    e.tag = tag;
    e.we  = good;
    e.ill = !good;
    e.vt  = vt;
    if (good) begin
      code = 0;
      while ((8 << code) < nwidth) code++;
      e.vt[5:3] = 3'(code);
      e.vt[2:0] = 3'(nlexp);
      if (rs2[3]) e.vt[6] = 1'b1;
      if (rs2[4]) e.vt[7] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic apply(input logic [4:0] rd, input logic [4:0] rs1,
                       input logic [4:0] rs2, input logic [XLEN-1:0] vt,
                       input string tag);
    @(negedge clk);
    rd_fld = rd; rs1_fld = rs1; rs2_fld = rs2; vtype_cur = vt;
    op_valid = 1'b1;
    sb.push_back(model(rd, rs1, rs2, vt, tag));
    @(negedge clk);
    op_valid = 1'b0;
    rd_fld = '0; rs1_fld = '0; rs2_fld = '0;
  endtask

  // Monitor: compares 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (monitor_on) begin
        if (sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          check(vtype_we == e.we, e.tag, "we", {31'd0, vtype_we}, {31'd0, e.we});
          check(illegal_op == e.ill, e.tag, "illegal", {31'd0, illegal_op}, {31'd0, e.ill});
          check(vtype_nxt == e.vt, e.tag, "vtype", vtype_nxt, e.vt);
        end else begin
          check(!vtype_we && !illegal_op, "R2", "idle strobes",
                {30'd0, vtype_we, illegal_op}, '0);
        end
      end
    end
  end

  initial begin
    fork
      begin : wd
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : run
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(vtype_nxt == '0 && !vtype_we && !illegal_op, "R1", "reset",
              {vtype_nxt[29:0], vtype_we, illegal_op}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(vtype_nxt == '0 && !vtype_we && !illegal_op, "R1", "after release",
              {vtype_nxt[29:0], vtype_we, illegal_op}, '0);
        monitor_on = 1'b1;
        // R3: width 32, mult 1, k=+1 -> width 64, mult 2
        apply(5'd0, 5'd0, 5'b00001, 32'h0000_0010, "R3 up1");
        // R3: width 8, mult 1/8, k=+3 -> width 64, mult 1
        apply(5'd0, 5'd0, 5'b00011, 32'h0000_0005, "R3 up3");
        // R3: width 64, mult 8, k=-3 -> width 8, mult 1
        apply(5'd0, 5'd0, 5'b00101, 32'h0000_001B, "R3 down3");
        // R3/R10: k=0 keeps word
        apply(5'd0, 5'd0, 5'b00000, 32'h0000_000A, "R10 k0");
        // R4: width 16, mult 4, k=+2 -> mult 16
        apply(5'd0, 5'd0, 5'b00010, 32'h0000_000A, "R4 mult>8");
        // R5: width 64, k=+1
        apply(5'd0, 5'd0, 5'b00001, 32'h0000_0018, "R5 width>64");
        // R5: width 8, k=-1
        apply(5'd0, 5'd0, 5'b00111, 32'h0000_0000, "R5 width<8");
        // R5: width 32, mult 1/4, k=-2 -> mult 1/16
        apply(5'd0, 5'd0, 5'b00110, 32'h0000_0016, "R5 mult<1/8");
        // R6: reserved fields
        apply(5'd1, 5'd0, 5'b00001, 32'h0000_0008, "R6 rd");
        apply(5'd0, 5'd2, 5'b00001, 32'h0000_0008, "R6 rs1");
        // R7: invalid configuration and reserved codes
        apply(5'd0, 5'd0, 5'b00001, 32'h8000_0008, "R7 vill");
        apply(5'd0, 5'd0, 5'b00000, 32'h0000_0028, "R7 width code 5");
        apply(5'd0, 5'd0, 5'b00000, 32'h0000_0004, "R7 mult code 4");
        apply(5'd0, 5'd0, 5'b00100, 32'h0000_0008, "R7 scale code 4");
        // R8: flag set with upper bits kept
        apply(5'd0, 5'd0, 5'b01001, 32'h0010_0008, "R8 tail");
        apply(5'd0, 5'd0, 5'b10000, 32'h0400_0040, "R8 mask");
        apply(5'd0, 5'd0, 5'b00000, 32'h0000_00C8, "R8 keep flags");
        // R9: failure keeps flags/word even with selects set
        apply(5'd0, 5'd0, 5'b11010, 32'h0000_001A, "R9 fail passthru");
        // R2: back-to-back strobes
        @(negedge clk);
        rs2_fld = 5'b00001; vtype_cur = 32'h0000_0008; op_valid = 1'b1;
        sb.push_back(model(5'd0, 5'd0, 5'b00001, 32'h0000_0008, "R2 b2b a"));
        @(negedge clk);
        rs2_fld = 5'b00001; vtype_cur = 32'h0000_0018;
        sb.push_back(model(5'd0, 5'd0, 5'b00001, 32'h0000_0018, "R2 b2b b"));
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        disable wd;
      end
    join
    if (sb.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2 pending results: actual %0d expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule